// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the two ALU inputs of a five-stage, in-order integer pipeline. Every instruction reads registers early and writes its result only in the last stage, so the only ordering problem is an instruction reading a register that an older instruction has not yet written back. For each source register of the instruction entering execute, the block compares the register number with the destination numbers held in the two later pipeline registers. These are the memory-stage register (the younger producer) and the write-back-stage register (the older producer). It then picks the value the ALU should use.

Each operand is decided independently. A producer may supply a value only when its write enable is set and its destination is not register 0, which always reads as zero. When both producers write the register being read, as in a chain of instructions that each update the same register, the younger memory-stage result wins. When the write-back producer is a load, the value it supplies is the loaded memory word rather than its ALU result. The chosen select codes and operand values are registered in one pipeline stage, so the ALU sees them one clock after the inputs are presented.

Top module: `fwd_unit`

## Requirements
- R1: While reset is asserted, both select outputs read 2'b00 and both operand outputs read zero, whatever the inputs.
- R2: When neither later stage has a matching, enabled, nonzero destination, the select is 2'b00 and the operand equals the register-file value.
- R3: When only the memory-stage producer matches a source (write enable set, destination nonzero and equal), the select is 2'b10 and the operand equals the memory-stage ALU result.
- R4: When only the write-back producer matches a source, the select is 2'b01 and the operand equals the write-back value.
- R5: When both producers match the same source, the select is 2'b10 and the memory-stage result is used.
- R6: A producer whose destination is register 0 never supplies a value, even with its write enable set. A source of register 0 always gets select 2'b00.
- R7: A producer whose write enable is clear never supplies a value, even when its destination matches.
- R8: The write-back value is the memory data input when the write-back load flag is 1 and the write-back ALU result when it is 0.
- R9: Operand A (first source) and operand B (second source) are decided independently. Both may be bypassed in the same cycle, from the same stage or from different stages.
- R10: Selects and operands appear exactly one clock after their inputs are sampled. Back-to-back inputs produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_rs1 | input | ADDR_W | First source register of the execute instruction |
| ex_rs2 | input | ADDR_W | Second source register of the execute instruction |
| ex_rf_a | input | DATA_W | Register-file value read for the first source |
| ex_rf_b | input | DATA_W | Register-file value read for the second source |
| exmem_rd | input | ADDR_W | Destination register of the memory-stage instruction |
| exmem_wen | input | 1 | Memory-stage instruction writes a register |
| exmem_alu | input | DATA_W | Memory-stage ALU result |
| memwb_rd | input | ADDR_W | Destination register of the write-back instruction |
| memwb_wen | input | 1 | Write-back instruction writes a register |
| memwb_is_load | input | 1 | Write-back instruction is a load |
| memwb_alu | input | DATA_W | Write-back ALU result |
| memwb_mem | input | DATA_W | Write-back loaded memory data |
| fwd_sel_a | output | 2 | Select code for operand A: 00 register file, 10 memory stage, 01 write-back |
| fwd_sel_b | output | 2 | Select code for operand B, same encoding |
| op_a | output | DATA_W | Value delivered to ALU input A |
| op_b | output | DATA_W | Value delivered to ALU input B |

## Verification
A wrong comparison or priority shows as a wrong select code and a wrong operand value on the very next clock after the offending inputs. Each check therefore compares both outputs for every input pattern. A wrong write-back source choice changes only the operand value, with the select still 01, so load and non-load write-back cases use different data words. A lost or extra register stage shows as every result shifting by one cycle, which the back-to-back chain exposes.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src_reg,
    input  logic [ADDR_W-1:0] dst_reg,
    input  logic              wr_en,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst_reg != ZERO_REG) && (dst_reg == src_reg);
    end
endmodule

// File: rtl/fwd_priority.sv
module fwd_priority
    import fwd_pkg::*;
(
    input  logic     hit_young,
    input  logic     hit_old,
    output fwd_sel_e sel
);
    always_comb begin
        if (hit_young) begin
            sel = SRC_EXMEM;
        end else if (hit_old) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_RF;
        end
    end
endmodule

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              is_load,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] wb_val
);
    always_comb begin
        wb_val = is_load ? mem_data : alu_res;
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] young_val,
    input  logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] out_val
);
    always_comb begin
        case (sel)
            SRC_EXMEM: out_val = young_val;
            SRC_MEMWB: out_val = old_val;
            default:   out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ex_rs1,
    input  logic [ADDR_W-1:0] ex_rs2,
    input  logic [DATA_W-1:0] ex_rf_a,
    input  logic [DATA_W-1:0] ex_rf_b,
    input  logic [ADDR_W-1:0] exmem_rd,
    input  logic              exmem_wen,
    input  logic [DATA_W-1:0] exmem_alu,
    input  logic [ADDR_W-1:0] memwb_rd,
    input  logic              memwb_wen,
    input  logic              memwb_is_load,
    input  logic [DATA_W-1:0] memwb_alu,
    input  logic [DATA_W-1:0] memwb_mem,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    localparam int unsigned NOPS = 2;

    typedef struct packed {
        logic [1:0]        sel_a;
        logic [1:0]        sel_b;
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
    } st_t;

    logic [ADDR_W-1:0] src_reg [NOPS];
    logic [DATA_W-1:0] rf_val  [NOPS];
    fwd_sel_e          sel_c   [NOPS];
    logic [DATA_W-1:0] val_c   [NOPS];
    logic [DATA_W-1:0] wb_val;

    assign src_reg[0] = ex_rs1;
    assign src_reg[1] = ex_rs2;
    assign rf_val[0]  = ex_rf_a;
    assign rf_val[1]  = ex_rf_b;

    fwd_wb_value #(.DATA_W(DATA_W)) u_wb (
        .is_load (memwb_is_load),
        .alu_res (memwb_alu),
        .mem_data(memwb_mem),
        .wb_val  (wb_val)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        logic hit_em;
        logic hit_wb;

        fwd_stage_match #(.ADDR_W(ADDR_W)) u_match_em (
            .src_reg(src_reg[g]),
            .dst_reg(exmem_rd),
            .wr_en  (exmem_wen),
            .hit    (hit_em)
        );

        fwd_stage_match #(.ADDR_W(ADDR_W)) u_match_wb (
            .src_reg(src_reg[g]),
            .dst_reg(memwb_rd),
            .wr_en  (memwb_wen),
            .hit    (hit_wb)
        );

        fwd_priority u_pri (
            .hit_young(hit_em),
            .hit_old  (hit_wb),
            .sel      (sel_c[g])
        );

        fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel      (sel_c[g]),
            .rf_val   (rf_val[g]),
            .young_val(exmem_alu),
            .old_val  (wb_val),
            .out_val  (val_c[g])
        );
    end

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sel_a = sel_c[0];
        st_d.sel_b = sel_c[1];
        st_d.val_a = val_c[0];
        st_d.val_b = val_c[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_sel_a = st_q.sel_a;
    assign fwd_sel_b = st_q.sel_b;
    assign op_a      = st_q.val_a;
    assign op_b      = st_q.val_b;

    // Assertions

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00 && op_a == '0 && op_b == '0));

    p_sel_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_sel_a) && $onehot0(fwd_sel_b));

    p_young_wins_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_wen && exmem_rd != '0 && exmem_rd == ex_rs1)
        |=> (fwd_sel_a == 2'b10 && op_a == $past(exmem_alu)));

    p_young_wins_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_wen && exmem_rd != '0 && exmem_rd == ex_rs2)
        |=> (fwd_sel_b == 2'b10 && op_b == $past(exmem_alu)));

    p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |=> (fwd_sel_a == 2'b00 && op_a == $past(ex_rf_a)));

    p_no_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exmem_wen && !memwb_wen) |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    p_old_load_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (memwb_wen && memwb_is_load && memwb_rd != '0 && memwb_rd == ex_rs1
         && !(exmem_wen && exmem_rd == ex_rs1))
        |=> (fwd_sel_a == 2'b01 && op_a == $past(memwb_mem)));

    p_old_alu_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (memwb_wen && !memwb_is_load && memwb_rd != '0 && memwb_rd == ex_rs2
         && !(exmem_wen && exmem_rd == ex_rs2))
        |=> (fwd_sel_b == 2'b01 && op_b == $past(memwb_alu)));

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        logic [1:0]        sa;
        logic [1:0]        sb;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] vb;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ex_rs1 = '0, ex_rs2 = '0, exmem_rd = '0, memwb_rd = '0;
    logic [DATA_W-1:0] ex_rf_a = '0, ex_rf_b = '0, exmem_alu = '0, memwb_alu = '0, memwb_mem = '0;
    logic              exmem_wen = 1'b0, memwb_wen = 1'b0, memwb_is_load = 1'b0;
    logic [1:0]        fwd_sel_a, fwd_sel_b;
    logic [DATA_W-1:0] op_a, op_b;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    fwd_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_alu(exmem_alu),
        .memwb_rd(memwb_rd), .memwb_wen(memwb_wen), .memwb_is_load(memwb_is_load),
        .memwb_alu(memwb_alu), .memwb_mem(memwb_mem),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .op_a(op_a), .op_b(op_b)
    );

    function automatic logic [1:0] pick(input logic [ADDR_W-1:0] src);
        if (exmem_wen && exmem_rd != 0 && exmem_rd == src) return 2'b10;
        if (memwb_wen && memwb_rd != 0 && memwb_rd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DATA_W-1:0] value(input logic [1:0] s, input logic [DATA_W-1:0] rf);
        if (s == 2'b10) return exmem_alu;
        if (s == 2'b01) return memwb_is_load ? memwb_mem : memwb_alu;
        return rf;
    endfunction

    task automatic apply(
        input logic [ADDR_W-1:0] rs1, input logic [ADDR_W-1:0] rs2,
        input logic [ADDR_W-1:0] erd, input logic ew,
        input logic [ADDR_W-1:0] wrd, input logic ww, input logic wld,
        input string tag);
        exp_t e;
        @(negedge clk);
        ex_rs1 = rs1; ex_rs2 = rs2;
        ex_rf_a = 32'hAAAA_0000 + 32'(rs1);
        ex_rf_b = 32'hBBBB_0000 + 32'(rs2);
        exmem_rd = erd; exmem_wen = ew; exmem_alu = 32'hE0E0_0000 + 32'(erd);
        memwb_rd = wrd; memwb_wen = ww; memwb_is_load = wld;
        memwb_alu = 32'hC0C0_0000 + 32'(wrd);
        memwb_mem = 32'hD0D0_0000 + 32'(wrd);
        e.sa = pick(rs1);
        e.sb = pick(rs2);
        e.va = value(e.sa, ex_rf_a);
        e.vb = value(e.sb, ex_rf_b);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (fwd_sel_a !== e.sa || fwd_sel_b !== e.sb || op_a !== e.va || op_b !== e.vb) begin
                    errors++;
                    $display("FAIL %s: actual sel_a=%b sel_b=%b a=%h b=%h expected sel_a=%b sel_b=%b a=%h b=%h",
                             t, fwd_sel_a, fwd_sel_b, op_a, op_b, e.sa, e.sb, e.va, e.vb);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with inputs that would otherwise bypass
        ex_rs1 = 5'd3; ex_rs2 = 5'd3; exmem_rd = 5'd3; exmem_wen = 1'b1;
        exmem_alu = 32'h1234_5678; memwb_rd = 5'd3; memwb_wen = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (fwd_sel_a !== 2'b00 || fwd_sel_b !== 2'b00 || op_a !== '0 || op_b !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual sel_a=%b sel_b=%b a=%h b=%h expected 00 00 0 0",
                     fwd_sel_a, fwd_sel_b, op_a, op_b);
        end
        rst_n = 1'b1;

        apply(5'd2, 5'd3, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, "R2 no hazard");
        apply(5'd5, 5'd3, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, "R3 memory stage to A");
        apply(5'd2, 5'd5, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, "R3 memory stage to B");
        apply(5'd6, 5'd3, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, "R4 write-back ALU to A");
        apply(5'd2, 5'd6, 5'd5, 1'b1, 5'd6, 1'b1, 1'b1, "R8 write-back load to B");
        apply(5'd6, 5'd2, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, "R8 write-back non-load to A");
        apply(5'd1, 5'd2, 5'd1, 1'b1, 5'd1, 1'b1, 1'b1, "R5 double match on A");
        apply(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 1'b0, "R5 double match on both");
        apply(5'd0, 5'd4, 5'd0, 1'b1, 5'd7, 1'b1, 1'b0, "R6 memory stage writes r0");
        apply(5'd4, 5'd0, 5'd7, 1'b1, 5'd0, 1'b1, 1'b1, "R6 write-back writes r0");
        apply(5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 1'b0, "R7 enables clear");
        apply(5'd9, 5'd8, 5'd9, 1'b0, 5'd9, 1'b1, 1'b1, "R7 disabled younger, older used");
        apply(5'd12, 5'd13, 5'd12, 1'b1, 5'd13, 1'b1, 1'b1, "R9 A from memory stage, B from write-back");
        apply(5'd13, 5'd12, 5'd12, 1'b1, 5'd13, 1'b1, 1'b0, "R9 A from write-back, B from memory stage");
        // R10: back-to-back chain r1 = r1 + rX
        apply(5'd1, 5'd2, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, "R10 chain step 1");
        apply(5'd1, 5'd3, 5'd1, 1'b1, 5'd1, 1'b1, 1'b0, "R10 chain step 2");
        apply(5'd1, 5'd4, 5'd1, 1'b1, 5'd1, 1'b1, 1'b0, "R10 chain step 3");
        apply(5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1, 1'b0, "R10 top register numbers");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule